// File: doc/BRIEF.md
# Bus Transaction Timeout Monitor

This block supervises two independent buses, a system bus and a local bus. It detects any transaction that waits too long for its acknowledge. Each bus has a cycle counter. The counter is armed when the bus signals a transaction start and is cleared by that bus's acknowledge. If the acknowledge does not arrive within the programmed window, the counter raises a one-cycle error pulse for that bus.

One 8-bit timing code sets the window for both buses. The window is counted in steps of eight clocks, so a code of 0xFF gives 2040 (0x7F8) cycles. A code of zero is an illegal setting, and with it every started transaction is reported as failed. The register that holds the code, and its reset value of 0xFF, live outside this block. Each bus has its own enable input.

A single action select routes any timeout. The timeout becomes a machine-check interrupt when the select is 0, or a soft-reset request when it is 1. The same select also serves the software watchdog elsewhere in the chip.

Top module: `bus_tmo_monitor`

## Requirements
- R1: While reset is high, and in the first cycle after it falls with no bus activity, `sys_err`, `loc_err`, `mchk_irq` and `soft_rst_req` are all 0.
- R2: The timeout window is `tmo_code` × 8 cycles. Call the clock edge that samples a start with the enable high E0. If no acknowledge is sampled on edges E1 to E(window), that bus's error output is 1 for exactly the one cycle after edge E(window).
- R3: An acknowledge sampled on any edge E1 to E(window) ends the transaction without an error. This includes the edge E(window) itself.
- R4: With `tmo_code` equal to 0, every start sampled with the enable high produces an error pulse in the cycle right after E0.
- R5: At most one error is raised per transaction. After the error or the acknowledge, the bus stays idle until its next start, and an acknowledge seen while idle has no effect.
- R6: A bus whose enable is 0 never raises its error. Dropping the enable during a transaction abandons that transaction, and raising the enable again does not bring it back.
- R7: A start sampled while a transaction is still outstanding restarts the window from that edge. A start and an acknowledge on the same edge count as a new start.
- R8: The two buses are timed independently from the shared code. Activity on one bus never changes the timing or the error of the other.
- R9: In a cycle where either error output is 1, `mchk_irq` is 1 if `act_sel` is 0 and `soft_rst_req` is 1 if `act_sel` is 1. In every other cycle both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_code | input | 8 | Shared timeout code, in units of 8 cycles |
| sys_en | input | 1 | System bus monitor enable |
| loc_en | input | 1 | Local bus monitor enable |
| act_sel | input | 1 | Timeout action: 0 interrupt, 1 soft reset |
| sys_start | input | 1 | System bus transaction start |
| sys_ack | input | 1 | System bus transaction acknowledge |
| loc_start | input | 1 | Local bus transaction start |
| loc_ack | input | 1 | Local bus transaction acknowledge |
| sys_err | output | 1 | System bus timeout pulse |
| loc_err | output | 1 | Local bus timeout pulse |
| mchk_irq | output | 1 | Machine-check interrupt request |
| soft_rst_req | output | 1 | Soft-reset request |

## Verification
The assertions check four rules on every cycle:
- A disabled bus is silent.
- An acknowledge on the final edge of the window blocks the error.
- Once an error has fired, no second error follows without a new start.
- A zero code fails a start immediately, and any error reaches exactly one of the two routed outputs.

Only the bench's scenarios can show that the pulse lands on exactly the cycle the code implies. To do this, the bench sweeps many code values, acknowledge positions, both buses and both action settings. The same goes for restart in mid-window, for abandonment when the enable drops, and for two buses timing out at staggered cycles from one shared code.

// File: rtl/bus_tmo_pkg.sv
package bus_tmo_pkg;

    localparam int CODE_W     = 8;
    localparam int STEP_SHIFT = 3;
    localparam int TICK_W     = CODE_W + STEP_SHIFT;
    localparam int BUS_COUNT  = 2;

    typedef logic [TICK_W-1:0] tick_t;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_WAIT = 1'b1
    } ch_state_e;

    typedef enum logic {
        ACT_MCHK = 1'b0,
        ACT_SRST = 1'b1
    } action_e;

    typedef struct packed {
        logic en;
        logic start;
        logic ack;
    } bus_req_t;

    // Window length in cycles: code scaled by the step size.
    function automatic tick_t window_of(input logic [CODE_W-1:0] code);
        return tick_t'(code) << STEP_SHIFT;
    endfunction

endpackage

// File: rtl/bus_tmo_channel.sv
module bus_tmo_channel
    import bus_tmo_pkg::*;
#(
    parameter int CNT_W = TICK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] window,
    input  bus_req_t         req,
    output logic             err
);

    ch_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             window_zero;
    logic             expire;

    assign cnt_next    = cnt + CNT_W'(1);
    assign window_zero = (window == '0);
    assign expire      = (cnt_next >= window);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CH_IDLE;
            cnt   <= '0;
            err   <= 1'b0;
        end else begin
            err <= 1'b0;
            if (!req.en) begin
                state <= CH_IDLE;
                cnt   <= '0;
            end else if (req.start) begin
                cnt <= '0;
                if (window_zero) begin
                    err   <= 1'b1;
                    state <= CH_IDLE;
                end else begin
                    state <= CH_WAIT;
                end
            end else if (state == CH_WAIT) begin
                if (req.ack) begin
                    state <= CH_IDLE;
                end else if (expire) begin
                    err   <= 1'b1;
                    state <= CH_IDLE;
                end else begin
                    cnt <= cnt_next;
                end
            end
        end
    end

    // R6
    disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(req.en));

    // R5
    single_err_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !req.start) |=> !err);

    // R3
    ack_blocks_err_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !($past(state == CH_WAIT) && $past(req.ack) && !$past(req.start)));

    // R4
    zero_code_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (req.en && req.start && window_zero) |=> err);

endmodule

// File: rtl/tmo_action_router.sv
module tmo_action_router
    import bus_tmo_pkg::*;
#(
    parameter int N_BUS = BUS_COUNT
) (
    input  logic [N_BUS-1:0] errs,
    input  logic             act_sel,
    output logic             mchk_irq,
    output logic             soft_rst_req
);

    logic    any_err;
    action_e action;

    assign any_err      = |errs;
    assign action       = action_e'(act_sel);
    assign mchk_irq     = any_err && (action == ACT_MCHK);
    assign soft_rst_req = any_err && (action == ACT_SRST);

endmodule

// File: rtl/bus_tmo_monitor.sv
module bus_tmo_monitor
    import bus_tmo_pkg::*;
#(
    parameter int CW    = CODE_W,
    parameter int N_BUS = BUS_COUNT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] tmo_code,
    input  logic          sys_en,
    input  logic          loc_en,
    input  logic          act_sel,
    input  logic          sys_start,
    input  logic          sys_ack,
    input  logic          loc_start,
    input  logic          loc_ack,
    output logic          sys_err,
    output logic          loc_err,
    output logic          mchk_irq,
    output logic          soft_rst_req
);

    localparam int WIN_W = CW + STEP_SHIFT;

    logic [WIN_W-1:0] window;
    bus_req_t         reqs [N_BUS];
    logic [N_BUS-1:0] errs;

    assign window = WIN_W'(window_of(CODE_W'(tmo_code)));

    assign reqs[0] = '{en: sys_en, start: sys_start, ack: sys_ack};
    assign reqs[1] = '{en: loc_en, start: loc_start, ack: loc_ack};

    for (genvar b = 0; b < N_BUS; b++) begin : g_bus
        bus_tmo_channel #(
            .CNT_W (WIN_W)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .window (window),
            .req    (reqs[b]),
            .err    (errs[b])
        );
    end

    assign sys_err = errs[0];
    assign loc_err = errs[1];

    tmo_action_router #(
        .N_BUS (N_BUS)
    ) u_route (
        .errs         (errs),
        .act_sel      (act_sel),
        .mchk_irq     (mchk_irq),
        .soft_rst_req (soft_rst_req)
    );

    // R9
    route_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        (sys_err || loc_err) |-> (mchk_irq != soft_rst_req));

    // R9
    route_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(sys_err || loc_err) |-> (!mchk_irq && !soft_rst_req));

endmodule

// File: tb/bus_tmo_monitor_test.sv
module bus_tmo_monitor_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] tmo_code;
    logic       sys_en, loc_en, act_sel;
    logic       sys_start, sys_ack, loc_start, loc_ack;
    logic       sys_err, loc_err, mchk_irq, soft_rst_req;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    bus_tmo_monitor uut (
        .clk(clk), .rst(rst), .tmo_code(tmo_code),
        .sys_en(sys_en), .loc_en(loc_en), .act_sel(act_sel),
        .sys_start(sys_start), .sys_ack(sys_ack),
        .loc_start(loc_start), .loc_ack(loc_ack),
        .sys_err(sys_err), .loc_err(loc_err),
        .mchk_irq(mchk_irq), .soft_rst_req(soft_rst_req)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_outs(input string req, input logic es, input logic el);
        chk(req, "sys_err", sys_err, es);
        chk(req, "loc_err", loc_err, el);
        chk("R9", "mchk_irq", mchk_irq, (es | el) & ~act_sel);
        chk("R9", "soft_rst_req", soft_rst_req, (es | el) & act_sel);
    endtask

    task automatic quiet();
        sys_start = 0; sys_ack = 0; loc_start = 0; loc_ack = 0;
    endtask

    // One transaction on one bus; ack_at = 0 means no acknowledge.
    task automatic txn(input int code, input int ack_at, input bit on_loc, input bit sel);
        int  win;
        logic e;
        string req;
        win = code * 8;
        @(negedge clk);
        tmo_code = 8'(code); act_sel = sel; sys_en = 1; loc_en = 1;
        if (on_loc) loc_start = 1; else sys_start = 1;
        @(negedge clk);
        quiet();
        e = (code == 0);
        chk_outs("R4", on_loc ? 1'b0 : e, on_loc ? e : 1'b0);
        for (int k = 1; k <= win + 2; k++) begin
            if (on_loc) loc_ack = (k == ack_at); else sys_ack = (k == ack_at);
            @(negedge clk);
            e = (code != 0) && (k == win) && !(ack_at >= 1 && ack_at <= win);
            if (ack_at == 0)        req = "R2";
            else if (ack_at <= win) req = "R3";
            else                    req = "R5";
            chk_outs(req, on_loc ? 1'b0 : e, on_loc ? e : 1'b0);
        end
        quiet();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1; tmo_code = 8'hFF; sys_en = 0; loc_en = 0; act_sel = 0;
        quiet();
        repeat (3) @(negedge clk);
        // R1 in reset
        chk_outs("R1", 1'b0, 1'b0);
        rst = 0;
        @(negedge clk);
        chk_outs("R1", 1'b0, 1'b0);

        // R2 R3 R4 R5 R9 sweep over small codes, both buses, both actions
        for (int sel = 0; sel < 2; sel++) begin
            for (int bus = 0; bus < 2; bus++) begin
                for (int code = 0; code <= 6; code++) begin
                    txn(code, 0, bus[0], sel[0]);
                    txn(code, 1, bus[0], sel[0]);
                    txn(code, code * 4, bus[0], sel[0]);
                    txn(code, code * 8, bus[0], sel[0]);
                    txn(code, code * 8 + 1, bus[0], sel[0]);
                end
            end
        end
        // R2 longer codes
        for (int code = 7; code <= 24; code++) txn(code, 0, 1'b0, 1'b0);
        // R2 R3 maximum code 0xFF -> 0x7F8 cycles
        txn(255, 0, 1'b0, 1'b0);
        txn(255, 2040, 1'b1, 1'b1);
        txn(255, 0, 1'b1, 1'b1);

        // R7 restart mid-window, code 1: second start at edge 5, error after edge 13
        tmo_code = 8'd1; act_sel = 0;
        @(negedge clk); sys_start = 1;
        for (int n = 1; n <= 16; n++) begin
            @(negedge clk);
            sys_start = (n == 5);
            chk_outs("R7", n == 14, 1'b0);
        end
        quiet();

        // R7 start with ack on same edge restarts
        @(negedge clk); sys_start = 1;
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            sys_start = (n == 3); sys_ack = (n == 3);
            chk_outs("R7", n == 12, 1'b0);
        end
        quiet();

        // R8 staggered buses on shared code
        act_sel = 1;
        @(negedge clk); sys_start = 1;
        for (int n = 1; n <= 14; n++) begin
            @(negedge clk);
            sys_start = 0;
            loc_start = (n == 3);
            chk_outs("R8", n == 9, n == 12);
        end
        quiet();

        // R6 drop enable mid-transaction, then re-enable
        act_sel = 0;
        @(negedge clk); sys_start = 1; loc_start = 1;
        for (int n = 1; n <= 14; n++) begin
            @(negedge clk);
            quiet();
            sys_en = !(n >= 4 && n < 6);
            loc_en = !(n >= 2 && n < 3);
            chk_outs("R6", 1'b0, 1'b0);
        end
        sys_en = 1; loc_en = 1;

        // R6 disabled start with zero code
        sys_en = 0; loc_en = 0; tmo_code = 8'd0;
        @(negedge clk); sys_start = 1; loc_start = 1;
        for (int n = 1; n <= 4; n++) begin
            @(negedge clk);
            chk_outs("R6", 1'b0, 1'b0);
        end
        quiet();

        // R5 acks while idle have no effect
        sys_en = 1; loc_en = 1; tmo_code = 8'd1;
        for (int n = 1; n <= 12; n++) begin
            @(negedge clk);
            sys_ack = n[0]; loc_ack = ~n[0];
            chk_outs("R5", 1'b0, 1'b0);
        end
        quiet();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule